// File: doc/BRIEF.md
# Configurable Mode SPI Master

This block is a single-byte SPI master for use inside a larger design. A client presents a transmit byte and pulses `start`. The block then issues exactly eight clock pulses on `sclk`. It shifts the byte out on `mosi` and, at the same time, collects one byte from `miso`. When the exchange ends it returns the received byte together with a one-cycle `done` pulse. Chip-select is not part of the block: the user drives it around one or more transfers.

Three configuration inputs select the transfer format. `cpol` sets the resting level of the clock. `cpha` chooses whether data is presented before the first edge or changed on it. `lsb_first` chooses the bit order. Together these give eight formats. The clock period is programmed at run time as a count of system cycles on `divisor`. The active half and the resting half of each pulse both last half of that count. In the data-first phase the block waits a quarter of the period between driving the first bit and making the first edge. All configuration is captured when a transfer is accepted.

Top module: `spi_mode_master`

## Requirements
- R1: While `rst` is high and in the cycle after it, `busy`, `done`, `rx_byte` and `mosi` are 0, and `sclk` equals `cpol`.
- R2: Between transfers `sclk` rests at `cpol`, following a change of `cpol` one cycle later. During a transfer each pulse moves `sclk` to the opposite of `cpol` for H cycles and then back to `cpol` for H cycles. H is the clamped divisor D shifted right by one.
- R3: Every accepted transfer makes exactly 8 pulses on `sclk`.
- R4: With `cpha`=0 the first data bit appears on `mosi` in the cycle after acceptance. The first edge follows after D>>2 further cycles. `miso` is sampled on the edge that leaves the resting level, and `mosi` moves to the next bit on the edge that returns to it.
- R5: With `cpha`=1 `mosi` keeps its old value until the first edge. Each edge that leaves the resting level puts the next bit on `mosi`, and `miso` is sampled on each edge that returns to the resting level.
- R6: With `lsb_first`=1 bit 0 of the transmit byte goes out first and the first bit sampled lands in `rx_byte` bit 0. With `lsb_first`=0 bit 7 goes out first and the first bit sampled lands in bit 7.
- R7: A `divisor` value of 0 or 1 acts as 2, so H is 1 and there is no setup wait.
- R8: `start` is taken only while idle. A `start` pulse during a transfer starts nothing and does not change the transfer in progress.
- R9: `busy` rises in the cycle after acceptance and stays high for 1 + W + 15·H cycles, where W is D>>2 for `cpha`=0 and 0 for `cpha`=1. In the cycle `busy` falls, `done` is high for exactly one cycle and `rx_byte` holds the new byte.
- R10: After a transfer `mosi` keeps the last bit it drove and `sclk` stays at `cpol` until the next acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request a transfer (taken only while idle) |
| tx_byte | input | 8 | Byte to transmit, captured on acceptance |
| cpol | input | 1 | Clock resting level |
| cpha | input | 1 | 0: data before first edge; 1: data changes on first edge |
| lsb_first | input | 1 | 1: least significant bit first; 0: most significant first |
| divisor | input | 16 | SPI clock period in system cycles (values below 2 act as 2) |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse when `rx_byte` is updated |
| rx_byte | output | 8 | Last received byte |
| sclk | output | 1 | SPI clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
Every result is timed from the acceptance edge. `busy` and the first phase-0 bit appear one edge later. The k-th leading edge lands 1 + W + 2·H·k edges after acceptance, and each trailing edge comes H edges after its leading edge. `done` lands on the trailing edge of the eighth pulse. A behavioural model in the bench computes these edge indices from the captured configuration and compares `sclk`, `mosi`, `busy`, `done` and `rx_byte` on every falling clock edge. The model also drives `miso` so that each bit is valid only until its own sampling edge, so a sample taken one edge early or late returns a wrong byte. Further checks cover the busy length, the pulse count, an ignored mid-transfer start, and what the outputs hold after a transfer.

// File: rtl/spi_mode_pkg.sv
package spi_mode_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,   // waiting for start
    ST_SETUP,  // optional quarter-period wait before the first edge
    ST_ACT,    // sclk at the non-resting level
    ST_REST    // sclk back at the resting level between pulses
  } spi_state_t;
endpackage

// File: rtl/spi_tick_timer.sv
module spi_tick_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expire
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (load)
      cnt <= load_val;
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign expire = (cnt == '0);
endmodule

// File: rtl/spi_shift_path.sv
module spi_shift_path #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              lsb_now,
  input  logic              drive_first,
  input  logic [DATA_W-1:0] tx_word,
  input  logic              shift_out,
  input  logic              sample,
  input  logic              finish,
  input  logic              miso,
  output logic              mosi,
  output logic [DATA_W-1:0] rx_byte
);
  logic [DATA_W-1:0] tx_sh, rx_sh, tx_ord, tx_rev, rx_nxt, rx_rev;
  logic              lsb_l;

  // Bit reversal: MSB-first is the LSB-first path with both bytes mirrored.
  for (genvar i = 0; i < DATA_W; i++) begin : g_mirror
    assign tx_rev[i] = tx_word[DATA_W-1-i];
    assign rx_rev[i] = rx_nxt[DATA_W-1-i];
  end

  assign tx_ord = lsb_now ? tx_word : tx_rev;
  assign rx_nxt = sample ? {miso, rx_sh[DATA_W-1:1]} : rx_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sh   <= '0;
      rx_sh   <= '0;
      mosi    <= 1'b0;
      rx_byte <= '0;
      lsb_l   <= 1'b0;
    end else if (load) begin
      lsb_l <= lsb_now;
      rx_sh <= '0;
      if (drive_first) begin
        mosi  <= tx_ord[0];
        tx_sh <= tx_ord >> 1;
      end else begin
        tx_sh <= tx_ord;
      end
    end else begin
      if (shift_out) begin
        mosi  <= tx_sh[0];
        tx_sh <= tx_sh >> 1;
      end
      rx_sh <= rx_nxt;
      if (finish)
        rx_byte <= lsb_l ? rx_nxt : rx_rev;
    end
  end

  // R6: the received byte only changes when a transfer finishes
  a_r6_rx_only_at_finish: assert property (@(posedge clk) disable iff (rst)
    (!finish && !load) |=> $stable(rx_byte));
endmodule

// File: rtl/spi_mode_master.sv
module spi_mode_master
  import spi_mode_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              lsb_first,
  input  logic [DIV_W-1:0]  divisor,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rx_byte,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso
);
  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);
  localparam logic [DIV_W-1:0] MIN_DIV  = DIV_W'(2);

  spi_state_t       st;
  logic             cpol_l, cpha_l;
  logic [DIV_W-1:0] half_l;
  logic [BIT_W-1:0] bit_cnt;
  logic             sclk_q, busy_q, done_q;

  logic [DIV_W-1:0] div_eff, quarter, tmr_val;
  logic accept, expire, lead_evt, trail_evt, last_pulse, tmr_load;
  logic shift_out, sample, finish;

  assign div_eff    = (divisor < MIN_DIV) ? MIN_DIV : divisor;
  assign quarter    = div_eff >> 2;
  assign accept     = (st == ST_IDLE) && start;
  assign lead_evt   = ((st == ST_SETUP) || (st == ST_REST)) && expire;
  assign trail_evt  = (st == ST_ACT) && expire;
  assign last_pulse = (bit_cnt == LAST_BIT);
  assign finish     = trail_evt && last_pulse;
  assign shift_out  = (lead_evt && cpha_l) || (trail_evt && !cpha_l && !last_pulse);
  assign sample     = (lead_evt && !cpha_l) || (trail_evt && cpha_l);
  assign tmr_load   = accept || lead_evt || (trail_evt && !last_pulse);
  assign tmr_val    = accept ? (cpha ? '0 : quarter) : (half_l - 1'b1);

  spi_tick_timer #(.CNT_W(DIV_W)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .expire(expire)
  );

  spi_shift_path #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .load(accept), .lsb_now(lsb_first), .drive_first(!cpha),
    .tx_word(tx_byte), .shift_out(shift_out), .sample(sample), .finish(finish),
    .miso(miso), .mosi(mosi), .rx_byte(rx_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      sclk_q  <= cpol;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      bit_cnt <= '0;
      cpol_l  <= 1'b0;
      cpha_l  <= 1'b0;
      half_l  <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          sclk_q <= cpol;
          if (start) begin
            cpol_l  <= cpol;
            cpha_l  <= cpha;
            half_l  <= div_eff >> 1;
            bit_cnt <= '0;
            busy_q  <= 1'b1;
            st      <= ST_SETUP;
          end
        end
        ST_SETUP, ST_REST: begin
          if (expire) begin
            sclk_q <= ~cpol_l;
            st     <= ST_ACT;
          end
        end
        ST_ACT: begin
          if (expire) begin
            sclk_q  <= cpol_l;
            bit_cnt <= bit_cnt + 1'b1;
            if (last_pulse) begin
              busy_q <= 1'b0;
              done_q <= 1'b1;
              st     <= ST_IDLE;
            end else begin
              st <= ST_REST;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign sclk = sclk_q;
  assign busy = busy_q;
  assign done = done_q;

  // R9: done lasts one cycle and coincides with busy low
  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r9_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R8: a transfer only begins from a start request
  a_r8_busy_needs_start: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));
  // R2: resting clock level while idle
  a_r2_idle_level: assert property (@(posedge clk) disable iff (rst)
    (!busy && !done && $past(!busy) && $stable(cpol)) |-> (sclk == cpol));
  // R10: data line holds between transfers
  a_r10_mosi_hold: assert property (@(posedge clk) disable iff (rst)
    (!busy && $past(!busy)) |-> $stable(mosi));
endmodule

// File: tb/spi_mode_master_bench.sv
module spi_mode_master_bench;
  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic cpol = 1'b0, cpha = 1'b0, lsb = 1'b1, miso = 1'b0;
  logic [7:0]  tx = 8'h00, slave = 8'h00;
  logic [15:0] div = 16'd8;
  wire busy, done, sclk, mosi;
  wire [7:0] rx;

  always #5 clk = ~clk;

  spi_mode_master u_spi_mode_master (
    .clk(clk), .rst(rst), .start(start), .tx_byte(tx), .cpol(cpol), .cpha(cpha),
    .lsb_first(lsb), .divisor(div), .busy(busy), .done(done), .rx_byte(rx),
    .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Inputs as seen by the design at each rising edge
  logic rst_s, start_s, cpol_s, cpha_s, lsb_s;
  logic [7:0] tx_s, slave_s;
  logic [15:0] div_s;
  bit seen = 0;
  always @(posedge clk) begin
    rst_s <= rst; start_s <= start; cpol_s <= cpol; cpha_s <= cpha; lsb_s <= lsb;
    tx_s <= tx; slave_s <= slave; div_s <= div; seen <= 1'b1;
  end

  // Behavioural reference: edge indices counted from the acceptance edge
  bit act = 0;
  int n, h, L0, T7;
  bit m_cpol, m_cpha;
  logic [7:0] bw, sw, m_slave, exp_rx = 8'h00;
  logic exp_mosi = 1'b0;

  function automatic int leads(int k, int l0, int hh);
    int v;
    if (k < l0) return 0;
    v = (k - l0) / (2 * hh) + 1;
    return (v > 8) ? 8 : v;
  endfunction

  function automatic int trails(int k, int l0, int hh);
    int v;
    if (k < l0 + hh) return 0;
    v = (k - l0 - hh) / (2 * hh) + 1;
    return (v > 8) ? 8 : v;
  endfunction

  always @(negedge clk) begin
    if (seen && !finished) begin
      int ld, tr, d, s;
      logic e_sclk, e_busy, e_done;
      if (rst_s) begin
        act = 0; exp_mosi = 1'b0; exp_rx = 8'h00;
      end else if (act) begin
        n++;
      end else if (start_s) begin
        act = 1; n = 0;
        d = (div_s < 2) ? 2 : int'(div_s);
        h = d / 2;
        m_cpol = cpol_s; m_cpha = cpha_s; m_slave = slave_s;
        L0 = 1 + (cpha_s ? 0 : d / 4);
        T7 = L0 + 15 * h;
        for (int i = 0; i < 8; i++) begin
          bw[i] = lsb_s ? tx_s[i] : tx_s[7-i];
          sw[i] = lsb_s ? slave_s[i] : slave_s[7-i];
        end
      end
      ld = act ? leads(n, L0, h) : 0;
      tr = act ? trails(n, L0, h) : 0;
      if (act) begin
        if (!m_cpha) exp_mosi = bw[(tr > 7) ? 7 : tr];
        else if (ld > 0) exp_mosi = bw[ld-1];
        if (n == T7) exp_rx = m_slave;
      end
      e_sclk = act ? ((ld > tr) ? ~m_cpol : m_cpol) : cpol_s;
      e_busy = act && (n < T7);
      e_done = act && (n == T7);
      chk(sclk === e_sclk, "R2", "sclk", sclk, e_sclk);
      chk(mosi === exp_mosi, act ? (m_cpha ? "R5" : "R4") : "R10", "mosi", mosi, exp_mosi);
      chk(busy === e_busy, "R9", "busy", busy, e_busy);
      chk(done === e_done, "R9", "done", done, e_done);
      chk(rx === exp_rx, "R6", "rx_byte", rx, exp_rx);
      if (act && n == T7) act = 0;
      if (act) begin
        s = m_cpha ? tr : ld;
        miso = (s < 8) ? sw[s] : 1'b0;
      end else begin
        miso = 1'b0;
      end
    end
  end

  task automatic xfer(input bit cp, input bit ph, input bit lb, input logic [15:0] dv,
                      input logic [7:0] t, input logic [7:0] s, input bit poke);
    int d, exp_len, blen, pulses;
    logic prev;
    @(posedge clk); #1;
    cpol = cp; cpha = ph; lsb = lb; div = dv; tx = t; slave = s;
    repeat (2) @(posedge clk);
    #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0; tx = ~t;
    if (poke) begin
      fork
        begin
          repeat (5) @(posedge clk);
          #1 start = 1'b1; tx = 8'h5A;
          @(posedge clk); #1 start = 1'b0;
        end
      join_none
    end
    blen = 0; pulses = 0; prev = cp;
    do begin
      @(negedge clk);
      if (busy) blen++;
      if (sclk !== cp && prev === cp) pulses++;
      prev = sclk;
    end while (done !== 1'b1);
    d = (dv < 2) ? 2 : int'(dv);
    exp_len = 1 + (ph ? 0 : d / 4) + 15 * (d / 2);
    chk(blen == exp_len, (dv < 2) ? "R7" : "R9", "busy length", blen, exp_len);
    chk(pulses == 8, "R3", "pulse count", pulses, 8);
    chk(rx === s, "R6", "received byte", rx, s);
    repeat (4) @(negedge clk);
    if (poke) chk(busy === 1'b0, "R8", "no transfer after ignored start", busy, 0);
    chk(mosi === (lb ? t[7] : t[0]), "R10", "mosi held", mosi, lb ? t[7] : t[0]);
    chk(sclk === cp, "R10", "sclk resting", sclk, cp);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(busy === 1'b0, "R1", "busy in reset", busy, 0);
    chk(done === 1'b0, "R1", "done in reset", done, 0);
    chk(rx === 8'h00, "R1", "rx in reset", rx, 0);
    chk(mosi === 1'b0, "R1", "mosi in reset", mosi, 0);
    chk(sclk === cpol, "R1", "sclk in reset", sclk, cpol);
    @(posedge clk); #1 rst = 1'b0;
    for (int c = 0; c < 8; c++)
      xfer(c[1], c[0], c[2], 16'd8, 8'hB4 ^ 8'(c * 37), 8'h2D + 8'(c * 17), 1'b0);
    xfer(1'b0, 1'b0, 1'b1, 16'd0, 8'hC3, 8'h96, 1'b0);   // R7 clamp
    xfer(1'b1, 1'b1, 1'b0, 16'd1, 8'h81, 8'h7E, 1'b0);   // R7 clamp
    xfer(1'b0, 1'b0, 1'b0, 16'd3, 8'h0F, 8'hF1, 1'b0);   // zero setup wait
    xfer(1'b1, 1'b0, 1'b1, 16'd5, 8'hA5, 8'h3C, 1'b0);   // odd divisor
    xfer(1'b0, 1'b1, 1'b1, 16'd11, 8'h6E, 8'hD2, 1'b0);
    xfer(1'b0, 1'b0, 1'b0, 16'd6, 8'h11, 8'hEE, 1'b1);   // R8 poke
    xfer(1'b1, 1'b1, 1'b1, 16'd4, 8'hFE, 8'h01, 1'b1);   // R8 poke
    xfer(1'b0, 1'b1, 1'b0, 16'd2, 8'h00, 8'hFF, 1'b0);
    repeat (3) @(posedge clk);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule